// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

This block sits between a set of interrupt request sources and a processor core. Twenty-nine individually enabled sources are merged onto ten vector slots. Each slot is given one of two selectable priority levels. In any cycle, the arbiter chooses at most one slot and reports its vector address and level to the core. It also tracks which levels are currently being serviced, so that a handler can only be pre-empted by a strictly more urgent request.

There are three levels: low, high and top. The first two slots can be programmed as top or low. The other eight can be programmed as high or low. When a request is accepted, the bit for its level is set in a three-bit in-service record. When the core returns from a handler, the most urgent recorded level is removed. Sequencing the core itself is outside this block.

Top module: `nest_irq_arb`

## Requirements
- R1: On acceptance, `irq_vec` holds 0x03 + 8*i for winning slot i (slot 0 gives 0x03, slot 9 gives 0x4B).
- R2: `irq_lvl` reports the accepted level, encoded 1 = low, 2 = high, 3 = top. A slot whose `slot_up` bit is 0 is low. If the bit is 1, slots 0 and 1 are top and slots 2 to 9 are high.
- R3: A request is accepted only if its level is strictly greater than the most urgent level in service. With nothing in service, any level qualifies.
- R4: The highest pending level wins. Among equal levels, the lowest slot index, which is also the lowest vector, wins.
- R5: Sources map to slots in the following groups: 0 to slot 0; 1 to slot 1; 2-4 to slot 2; 5-8 to slot 3; 9-10 to slot 4; 11-13 to slot 5; 14-16 to slot 6; 17-20 to slot 7; 21-24 to slot 8; 25-28 to slot 9. A source counts only while its `src_en` bit is 1.
- R6: While `glb_en` is 0, no request is accepted.
- R7: `irq_take` pulses for one cycle on the clock edge after a qualifying request appears. The accepted level is then in service, so a request held at that level does not pulse again.
- R8: A cycle with `irq_ret` high removes the most urgent in-service level and accepts nothing. A return with nothing in service has no effect.
- R9: Synchronous reset clears `irq_take`, `irq_vec`, `irq_lvl` and the in-service record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 29 | Request lines from the sources |
| src_en | input | 29 | Per-source enable |
| glb_en | input | 1 | Global acceptance enable |
| slot_up | input | 10 | Per-slot level select (1 = upper level of that slot) |
| irq_ret | input | 1 | Return-from-handler pulse |
| irq_take | output | 1 | Accept strobe, one cycle |
| irq_vec | output | 8 | Vector address of the accepted slot |
| irq_lvl | output | 2 | Level of the accepted slot |

## Verification
The hardest state to reach from the ports is a fully nested stack, with low, high and top all in service at once, followed by unwinding it one level at a time. The in-service record is not visible at the ports. The stimulus therefore builds the nesting in steps: it holds a low request, then adds a high one, then a top one, and confirms each acceptance. After each return pulse, it checks that held requests stay refused until the current level has dropped below theirs. At that point, the lower-indexed of two waiting high slots must be the one accepted.

// File: rtl/nest_irq_arb_pkg.sv
`timescale 1ns/1ps
package nest_irq_arb_pkg;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_LOW  = 2'd1;
  localparam lvl_t LVL_HIGH = 2'd2;
  localparam lvl_t LVL_TOP  = 2'd3;

  // number of request sources merged onto each slot
  function automatic int slot_width(input int s);
    case (s)
      0, 1:       return 1;
      2, 5, 6:    return 3;
      4:          return 2;
      3, 7, 8, 9: return 4;
      default:    return 0;
    endcase
  endfunction

  // index of the first source of a slot
  function automatic int slot_base(input int s);
    int acc;
    acc = 0;
    for (int k = 0; k < s; k++) acc += slot_width(k);
    return acc;
  endfunction

endpackage

// File: rtl/nest_irq_gather.sv
`timescale 1ns/1ps
module nest_irq_gather
  import nest_irq_arb_pkg::*;
#(
  parameter int N_SLOTS = 10,
  parameter int N_SRC   = 29
) (
  input  logic [N_SRC-1:0]   src_req,
  input  logic [N_SRC-1:0]   src_en,
  output logic [N_SLOTS-1:0] slot_pend
);

  logic [N_SRC-1:0] live;
  assign live = src_req & src_en;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    localparam int FIRST = slot_base(s);
    localparam int CNT   = slot_width(s);
    assign slot_pend[s] = |live[FIRST +: CNT];
  end

endmodule

// File: rtl/nest_irq_pick.sv
`timescale 1ns/1ps
module nest_irq_pick
  import nest_irq_arb_pkg::*;
#(
  parameter int N_SLOTS = 10,
  parameter int N_TOPSL = 2,
  localparam int IDX_W  = $clog2(N_SLOTS)
) (
  input  logic [N_SLOTS-1:0] slot_pend,
  input  logic [N_SLOTS-1:0] slot_up,
  input  lvl_t               cur_lvl,
  output logic               win_ok,
  output logic [IDX_W-1:0]   win_idx,
  output lvl_t               win_lvl
);

  lvl_t slot_lvl [N_SLOTS];

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_lvl
    localparam lvl_t UPPER = (s < N_TOPSL) ? LVL_TOP : LVL_HIGH;
    assign slot_lvl[s] = !slot_pend[s] ? LVL_NONE :
                         (slot_up[s] ? UPPER : LVL_LOW);
  end

  // descending scan with >= lets the lower index win ties
  always_comb begin
    win_lvl = LVL_NONE;
    win_idx = '0;
    for (int s = N_SLOTS-1; s >= 0; s--) begin
      if (slot_lvl[s] != LVL_NONE && slot_lvl[s] >= win_lvl) begin
        win_lvl = slot_lvl[s];
        win_idx = IDX_W'(s);
      end
    end
    win_ok = (win_lvl != LVL_NONE) && (win_lvl > cur_lvl);
  end

endmodule

// File: rtl/nest_irq_stack.sv
`timescale 1ns/1ps
module nest_irq_stack
  import nest_irq_arb_pkg::*;
#(
  parameter int N_LVL = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output lvl_t cur_lvl
);

  logic [N_LVL-1:0] busy;
  logic [N_LVL-1:0] top_bit;

  always_comb begin
    cur_lvl = LVL_NONE;
    top_bit = '0;
    for (int k = 0; k < N_LVL; k++) begin
      if (busy[k]) begin
        cur_lvl = lvl_t'(k + 1);
        top_bit = '0;
        top_bit[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= '0;
    end else if (pop) begin
      busy <= busy & ~top_bit;
    end else if (push && push_lvl != LVL_NONE) begin
      busy[push_lvl - 2'd1] <= 1'b1;
    end
  end

  AST_PUSH_ABOVE: assert property (@(posedge clk) disable iff (rst)
    push |-> push_lvl > cur_lvl); // R3

  AST_POP_SHRINK: assert property (@(posedge clk) disable iff (rst)
    (pop && busy != '0) |=> $countones(busy) == $countones($past(busy)) - 1); // R8

  AST_POP_TOPMOST: assert property (@(posedge clk) disable iff (rst)
    (pop && busy != '0) |=> cur_lvl < $past(cur_lvl)); // R8

endmodule

// File: rtl/nest_irq_arb.sv
`timescale 1ns/1ps
module nest_irq_arb
  import nest_irq_arb_pkg::*;
#(
  parameter int N_SLOTS    = 10,
  parameter int N_SRC      = 29,
  parameter int N_TOPSL    = 2,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SRC-1:0]   src_req,
  input  logic [N_SRC-1:0]   src_en,
  input  logic               glb_en,
  input  logic [N_SLOTS-1:0] slot_up,
  input  logic               irq_ret,
  output logic               irq_take,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [1:0]         irq_lvl
);

  localparam int IDX_W   = $clog2(N_SLOTS);
  localparam int VEC_TOP = VEC_BASE + (N_SLOTS-1)*VEC_STRIDE;
  localparam int VEC_SPL = VEC_BASE + N_TOPSL*VEC_STRIDE;

  logic [N_SLOTS-1:0] slot_pend;
  logic               win_ok;
  logic [IDX_W-1:0]   win_idx;
  lvl_t               win_lvl;
  lvl_t               cur_lvl;
  logic               push;

  nest_irq_gather #(.N_SLOTS(N_SLOTS), .N_SRC(N_SRC)) u_gather (
    .src_req  (src_req),
    .src_en   (src_en),
    .slot_pend(slot_pend)
  );

  nest_irq_pick #(.N_SLOTS(N_SLOTS), .N_TOPSL(N_TOPSL)) u_pick (
    .slot_pend(slot_pend),
    .slot_up  (slot_up),
    .cur_lvl  (cur_lvl),
    .win_ok   (win_ok),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  assign push = glb_en && !irq_ret && win_ok;

  nest_irq_stack #(.N_LVL(3)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push    (push),
    .push_lvl(win_lvl),
    .pop     (irq_ret),
    .cur_lvl (cur_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_take <= 1'b0;
      irq_vec  <= '0;
      irq_lvl  <= LVL_NONE;
    end else begin
      irq_take <= push;
      if (push) begin
        irq_vec <= VEC_W'(VEC_BASE + int'(win_idx) * VEC_STRIDE);
        irq_lvl <= win_lvl;
      end
    end
  end

  AST_VEC_GRID: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> (int'(irq_vec) >= VEC_BASE && int'(irq_vec) <= VEC_TOP &&
                  (int'(irq_vec) - VEC_BASE) % VEC_STRIDE == 0)); // R1

  AST_TOP_SLOTS: assert property (@(posedge clk) disable iff (rst)
    (irq_take && irq_lvl == LVL_TOP) |-> int'(irq_vec) < VEC_SPL); // R2

  AST_HIGH_SLOTS: assert property (@(posedge clk) disable iff (rst)
    (irq_take && irq_lvl == LVL_HIGH) |-> int'(irq_vec) >= VEC_SPL); // R2

  AST_GLB_BLOCK: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> !irq_take); // R6

  AST_RET_BLOCK: assert property (@(posedge clk) disable iff (rst)
    irq_ret |=> !irq_take); // R8

  AST_TAKE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> irq_lvl != LVL_NONE); // R7

endmodule

// File: tb/nest_irq_arb_tb.sv
`timescale 1ns/1ps
module nest_irq_arb_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [28:0] src_req;
  logic [28:0] src_en;
  logic        glb_en;
  logic [9:0]  slot_up;
  logic        irq_ret;
  logic        irq_take;
  logic [7:0]  irq_vec;
  logic [1:0]  irq_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int first_src [10] = '{0, 1, 2, 5, 9, 11, 14, 17, 21, 25};

  always #2 clk = ~clk;

  nest_irq_arb u_dut (
    .clk(clk), .rst(rst), .src_req(src_req), .src_en(src_en),
    .glb_en(glb_en), .slot_up(slot_up), .irq_ret(irq_ret),
    .irq_take(irq_take), .irq_vec(irq_vec), .irq_lvl(irq_lvl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic take_is(input string tag, input int t, input int v, input int l);
    chk({tag, " take"}, int'(irq_take), t);
    if (t == 1) begin
      chk({tag, " vec"}, int'(irq_vec), v);
      chk({tag, " lvl"}, int'(irq_lvl), l);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; src_req = '0; src_en = '1; glb_en = 1'b1;
    slot_up = '0; irq_ret = 1'b0;
    cyc(); cyc();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; src_req = '1; src_en = '1; glb_en = 1'b1; slot_up = '1; irq_ret = 1'b0;
    cyc(); cyc();
    chk("R9 take", int'(irq_take), 0);
    chk("R9 vec", int'(irq_vec), 0);
    chk("R9 lvl", int'(irq_lvl), 0);
    rst = 1'b0; src_req = '0;
    cyc();
    chk("R9 idle", int'(irq_take), 0);
  endtask

  task automatic t_vectors();
    for (int s = 0; s < 10; s++) begin
      do_reset();
      src_req[first_src[s]] = 1'b1;
      cyc();
      take_is("R1 R5 slot", 1, 3 + 8*s, 1);
    end
  endtask

  task automatic t_levels();
    do_reset(); slot_up = '1; src_req[first_src[5]] = 1'b1;
    cyc(); take_is("R2 slot5 up", 1, 8'h2B, 2);
    do_reset(); slot_up = '1; src_req[first_src[1]] = 1'b1;
    cyc(); take_is("R2 slot1 up", 1, 8'h0B, 3);
    do_reset(); src_req[first_src[1]] = 1'b1;
    cyc(); take_is("R2 slot1 low", 1, 8'h0B, 1);
  endtask

  task automatic t_order();
    do_reset(); src_req[first_src[7]] = 1'b1; src_req[first_src[3]] = 1'b1;
    cyc(); take_is("R4 tie", 1, 8'h1B, 1);
    do_reset(); slot_up[9] = 1'b1; src_req[25] = 1'b1; src_req[2] = 1'b1;
    cyc(); take_is("R4 high beats low", 1, 8'h4B, 2);
    do_reset(); slot_up[1] = 1'b1; src_req[0] = 1'b1; src_req[1] = 1'b1;
    cyc(); take_is("R4 top beats low", 1, 8'h0B, 3);
  endtask

  task automatic t_nest();
    do_reset();
    slot_up = 10'b0000010101;
    src_req[14] = 1'b1;                 // slot 6 low
    cyc(); take_is("R3 low first", 1, 8'h33, 1);
    cyc(); take_is("R3 R7 equal low", 0, 0, 0);
    src_req[9] = 1'b1;                  // slot 4 high
    cyc(); take_is("R3 high nests", 1, 8'h23, 2);
    src_req[2] = 1'b1;                  // slot 2 high
    cyc(); take_is("R3 equal high", 0, 0, 0);
    src_req[0] = 1'b1;                  // slot 0 top
    cyc(); take_is("R3 top nests", 1, 8'h03, 3);
    src_req[0] = 1'b0;
    irq_ret = 1'b1;
    cyc(); take_is("R8 ret cycle", 0, 0, 0);
    irq_ret = 1'b0;
    cyc(); take_is("R8 high still busy", 0, 0, 0);
    irq_ret = 1'b1;
    cyc(); take_is("R8 ret blocks", 0, 0, 0);
    irq_ret = 1'b0;
    cyc(); take_is("R8 R4 after unwind", 1, 8'h13, 2);
  endtask

  task automatic t_ret_idle();
    do_reset();
    irq_ret = 1'b1; cyc(); irq_ret = 1'b0;
    src_req[5] = 1'b1; irq_ret = 1'b1;
    cyc(); take_is("R8 ret empty blocks", 0, 0, 0);
    irq_ret = 1'b0;
    cyc(); take_is("R8 after ret", 1, 8'h1B, 1);
  endtask

  task automatic t_enable();
    do_reset(); src_en = '0; src_req[3] = 1'b1;
    cyc(); take_is("R5 masked", 0, 0, 0);
    src_en[3] = 1'b1;
    cyc(); take_is("R5 enabled", 1, 8'h13, 1);
    do_reset(); src_req[8] = 1'b1;
    cyc(); take_is("R5 last of slot3", 1, 8'h1B, 1);
    do_reset(); src_req[28] = 1'b1; src_en[28] = 1'b0; src_req[20] = 1'b1;
    cyc(); take_is("R5 masked slot9", 1, 8'h3B, 1);
  endtask

  task automatic t_global();
    do_reset(); glb_en = 1'b0; src_req[first_src[4]] = 1'b1;
    cyc(); take_is("R6 off", 0, 0, 0);
    cyc(); take_is("R6 off hold", 0, 0, 0);
    glb_en = 1'b1;
    cyc(); take_is("R6 on", 1, 8'h23, 1);
  endtask

  task automatic t_strobe();
    do_reset(); src_req[21] = 1'b1;
    cyc(); take_is("R7 pulse", 1, 8'h43, 1);
    cyc(); take_is("R7 single", 0, 0, 0);
    cyc(); take_is("R7 stays low", 0, 0, 0);
    chk("R7 vec held", int'(irq_vec), 8'h43);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_vectors();
    t_levels();
    t_order();
    t_nest();
    t_ret_idle();
    t_enable();
    t_global();
    t_strobe();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule